// File: doc/BRIEF.md
# Signed Add/Subtract/Compare Unit

This unit performs two's-complement addition, subtraction and arithmetic comparison on two register-sized signed operands. It is the fixed-point arithmetic slice of an execution stage. A caller presents an operation code, two operands, a halfword flag and the overflow mask with a one-cycle valid strobe. One clock later the unit returns the wrapped result, a two-bit condition code, a result write enable and, when enabled by the mask, an overflow interrupt request.

In halfword mode only the low 16 bits of the second operand are used. They are sign-extended to full width before the operation. Comparison does not write a result. It produces only a condition code, and that code is computed from a difference one bit wider than the operands, so no pair of operands can be misordered.

Top module: `fxp_arith_unit`

## Requirements
- R1: With op = 2'b00 (add), the registered result equals the 32-bit wrapped sum of the two operands: any carry out of the sign bit is dropped.
- R2: With op = 2'b01 (subtract), the registered result equals the 32-bit wrapped value of operand A minus operand B.
- R3: When half_sel is 1, operand B is taken as bits 15:0 sign-extended to 32 bits, and bits 31:16 have no effect on any output.
- R4: For add and subtract, cc is 3 on signed overflow, whatever the result value. Otherwise cc is 0 for a zero result, 1 for a negative result and 2 for a positive result.
- R5: ovf_irq is 1 in the output cycle of an add or subtract that overflows while ovf_mask is 1. It is 0 in every other case, including overflow with ovf_mask = 0.
- R6: With op[1] = 1 (compare), cc is 0 when the operands are equal, 1 when A is lower and 2 when A is higher, both treated as signed. This ordering holds for the extreme values, and cc is never 3.
- R7: A compare drives result_wr to 0 and leaves result unchanged from its previous value. Add and subtract drive result_wr to 1.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1. A cycle without in_valid gives out_valid = 0 and ovf_irq = 0 one cycle later, and result and cc hold their values.
- R9: While rst_n is 0, out_valid, ovf_irq, result_wr, cc and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 00 add, 01 subtract, 1x compare |
| opnd_a | input | 32 | First operand, signed |
| opnd_b | input | 32 | Second operand, signed (low 16 bits in halfword mode) |
| half_sel | input | 1 | Halfword mode for operand B |
| ovf_mask | input | 1 | Enables the overflow interrupt request |
| out_valid | output | 1 | Result cycle marker |
| result | output | 32 | Wrapped sum or difference |
| result_wr | output | 1 | Result should be written back |
| cc | output | 2 | Condition code |
| ovf_irq | output | 1 | Fixed-point overflow interrupt request |

## Verification
Overflow detection and the interrupt request fall in the same output cycle. The wrapped result, the cc value of 3 and the masked request must therefore all agree on one edge. The bench provokes this with operands near the extremes, such as the largest positive value plus one, and with halfword operands that push a full-width A over the limit. It drives both mask values. Each output cycle is judged against a 64-bit reference computation of the exact result: that computation decides whether overflow occurred, and from it the bench computes the expected wrap, code and request.

// File: rtl/fxp_arith_pkg.sv
package fxp_arith_pkg;

   localparam logic [1:0] OPC_ADD = 2'b00;
   localparam logic [1:0] OPC_SUB = 2'b01;

   localparam logic [1:0] CC_ZERO = 2'd0;
   localparam logic [1:0] CC_NEG  = 2'd1;
   localparam logic [1:0] CC_POS  = 2'd2;
   localparam logic [1:0] CC_OVF  = 2'd3;

   localparam logic [1:0] CC_EQ   = 2'd0;
   localparam logic [1:0] CC_LOW  = 2'd1;
   localparam logic [1:0] CC_HIGH = 2'd2;

   typedef struct packed {
      logic       is_cmp;
      logic       is_sub;
   } op_dec_t;

   function automatic op_dec_t decode_op(input logic [1:0] opc);
      op_dec_t d;
      d.is_cmp = opc[1];
      d.is_sub = ~opc[1] & opc[0];
      return d;
   endfunction

endpackage

// File: rtl/fxp_operand_ext.sv
module fxp_operand_ext #(
   parameter int DATA_W  = 32,
   parameter int HALF_W  = 16,
   parameter bit HALF_EN = 1'b1
) (
   input  logic [DATA_W-1:0] b_in,
   input  logic              half_sel,
   output logic [DATA_W-1:0] b_out
);
   localparam int EXT_W = DATA_W - HALF_W;

   generate
      if (HALF_EN) begin : g_half
         logic [DATA_W-1:0] b_short;
         assign b_short = {{EXT_W{b_in[HALF_W-1]}}, b_in[HALF_W-1:0]};
         assign b_out   = half_sel ? b_short : b_in;
      end else begin : g_full
         logic unused_half;
         assign unused_half = half_sel;
         assign b_out       = b_in;
      end
   endgenerate

endmodule

// File: rtl/fxp_addsub.sv
module fxp_addsub #(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_CHAIN = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE_CHAIN) begin : g_ripple
         logic [DATA_W:0] carry;
         assign carry[0] = sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
         end
         assign ovf = carry[DATA_W] ^ carry[DATA_W-1];
      end else begin : g_behav
         logic [DATA_W-1:0] cin_ext;
         assign cin_ext = {{(DATA_W-1){1'b0}}, sub};
         assign sum     = a + b_eff + cin_ext;
         assign ovf     = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
      end
   endgenerate

endmodule

// File: rtl/fxp_compare.sv
module fxp_compare #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [1:0]        cmp_cc
);
   import fxp_arith_pkg::*;

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] a_wide;
   logic [DATA_W:0] b_wide;
   logic [DATA_W:0] diff;
   logic            a_lower;
   logic            same;

   assign a_wide  = {a[MSB], a};
   assign b_wide  = {b[MSB], b};
   assign diff    = a_wide - b_wide;
   assign a_lower = diff[DATA_W];
   assign same    = (diff == '0);

   always_comb begin
      if (same)         cmp_cc = CC_EQ;
      else if (a_lower) cmp_cc = CC_LOW;
      else              cmp_cc = CC_HIGH;
   end

endmodule

// File: rtl/fxp_arith_unit.sv
module fxp_arith_unit #(
   parameter int DATA_W       = 32,
   parameter int HALF_W       = 16,
   parameter bit HALF_EN      = 1'b1,
   parameter bit RIPPLE_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              half_sel,
   input  logic              ovf_mask,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              result_wr,
   output logic [1:0]        cc,
   output logic              ovf_irq
);
   import fxp_arith_pkg::*;

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("fxp_arith_unit: DATA_W must be at least 4");
      end
      if (HALF_EN && ((HALF_W < 2) || (HALF_W >= DATA_W))) begin : g_bad_half
         $error("fxp_arith_unit: HALF_W must lie in 2..DATA_W-1");
      end
   endgenerate

   op_dec_t           dec;
   logic [DATA_W-1:0] b_ext;
   logic [DATA_W-1:0] as_sum;
   logic              as_ovf;
   logic [1:0]        cmp_cc;
   logic [1:0]        as_cc;
   logic [1:0]        cc_next;
   logic              irq_next;

   assign dec = decode_op(op);

   fxp_operand_ext #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W),
      .HALF_EN(HALF_EN)
   ) u_ext (
      .b_in    (opnd_b),
      .half_sel(half_sel),
      .b_out   (b_ext)
   );

   fxp_addsub #(
      .DATA_W      (DATA_W),
      .RIPPLE_CHAIN(RIPPLE_CHAIN)
   ) u_addsub (
      .a  (opnd_a),
      .b  (b_ext),
      .sub(dec.is_sub),
      .sum(as_sum),
      .ovf(as_ovf)
   );

   fxp_compare #(
      .DATA_W(DATA_W)
   ) u_cmp (
      .a     (opnd_a),
      .b     (b_ext),
      .cmp_cc(cmp_cc)
   );

   always_comb begin
      if (as_ovf)              as_cc = CC_OVF;
      else if (as_sum == '0)   as_cc = CC_ZERO;
      else if (as_sum[MSB])    as_cc = CC_NEG;
      else                     as_cc = CC_POS;
   end

   assign cc_next  = dec.is_cmp ? cmp_cc : as_cc;
   assign irq_next = ~dec.is_cmp & as_ovf & ovf_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         result_wr <= 1'b0;
         cc        <= CC_ZERO;
         ovf_irq   <= 1'b0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         result_wr <= ~dec.is_cmp;
         cc        <= cc_next;
         ovf_irq   <= irq_next;
         if (!dec.is_cmp) result <= as_sum;
      end else begin
         out_valid <= 1'b0;
         result_wr <= 1'b0;
         ovf_irq   <= 1'b0;
      end
   end

   // R8: output strobe follows the input strobe by one cycle
   assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !ovf_irq && $stable(result) && $stable(cc)));

   // R5: request only alongside an overflow code of an add or subtract
   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (out_valid && result_wr && cc == CC_OVF));

   // R6: compare never reports the overflow code
   assert_cmp_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !result_wr) |-> (cc != CC_OVF));

   // R7: compare leaves the result untouched
   assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !result_wr) |-> $stable(result));

   // R4: zero and negative codes agree with the written result
   assert_zero_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result_wr && cc == CC_ZERO) |-> (result == '0));

   assert_neg_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result_wr && cc == CC_NEG) |-> result[MSB]);

   assert_pos_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result_wr && cc == CC_POS) |-> (!result[MSB] && result != '0));

endmodule

// File: tb/fxp_arith_unit_tb_top.sv
module fxp_arith_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        half_sel = 1'b0;
   logic        ovf_mask = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        result_wr;
   logic [1:0]  cc;
   logic        ovf_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] model_res = '0;

   always #4 clk = ~clk;

   fxp_arith_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .half_sel(half_sel), .ovf_mask(ovf_mask),
      .out_valid(out_valid), .result(result), .result_wr(result_wr),
      .cc(cc), .ovf_irq(ovf_irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic h, input logic m, input string req);
      longint sa, sb, r;
      logic [31:0] eres;
      logic [1:0]  ecc;
      logic        eirq, ewr, ov;
      sa = longint'($signed(a));
      sb = h ? longint'($signed(b[15:0])) : longint'($signed(b));
      if (o[1]) begin
         ewr = 1'b0; eirq = 1'b0; eres = model_res;
         ecc = (sa == sb) ? 2'd0 : (sa < sb) ? 2'd1 : 2'd2;
      end else begin
         r    = o[0] ? (sa - sb) : (sa + sb);
         eres = r[31:0];
         ov   = (r > 64'sd2147483647) || (r < -64'sd2147483648);
         ecc  = ov ? 2'd3 : (eres == 32'd0) ? 2'd0 : eres[31] ? 2'd1 : 2'd2;
         eirq = ov && m;
         ewr  = 1'b1;
      end
      op = o; opnd_a = a; opnd_b = b; half_sel = h; ovf_mask = m; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b1, "R8", "out_valid", {31'd0, out_valid}, 32'd1);
      chk(result === eres, req, "result", result, eres);
      chk(cc === ecc, req, "cc", {30'd0, cc}, {30'd0, ecc});
      chk(ovf_irq === eirq, "R5", "ovf_irq", {31'd0, ovf_irq}, {31'd0, eirq});
      chk(result_wr === ewr, "R7", "result_wr", {31'd0, result_wr}, {31'd0, ewr});
      model_res = eres;
      in_valid = 1'b0;
   endtask

   task automatic idle_cycle();
      logic [1:0] cc_before;
      cc_before = cc;
      in_valid = 1'b0;
      op = 2'($urandom); opnd_a = $urandom; opnd_b = $urandom; ovf_mask = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R8", "idle out_valid", {31'd0, out_valid}, 32'd0);
      chk(ovf_irq === 1'b0, "R8", "idle ovf_irq", {31'd0, ovf_irq}, 32'd0);
      chk(result === model_res, "R8", "idle result hold", result, model_res);
      chk(cc === cc_before, "R8", "idle cc hold", {30'd0, cc}, {30'd0, cc_before});
   endtask

   function automatic logic [31:0] pick();
      case ($urandom % 8)
         0: return 32'h0000_0000;
         1: return 32'h7FFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'hFFFF_FFFF;
         4: return 32'h0000_0001;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E_3D4C));
      in_valid = 1'b1;
      op = 2'b00; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h1; ovf_mask = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(out_valid === 1'b0, "R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
      chk(ovf_irq === 1'b0, "R9", "reset ovf_irq", {31'd0, ovf_irq}, 32'd0);
      chk(result_wr === 1'b0, "R9", "reset result_wr", {31'd0, result_wr}, 32'd0);
      chk(cc === 2'd0, "R9", "reset cc", {30'd0, cc}, 32'd0);
      chk(result === 32'd0, "R9", "reset result", result, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R1 add, including wrap and zero result
      apply(2'b00, 32'd5, 32'd7, 1'b0, 1'b0, "R1");
      apply(2'b00, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R1");
      apply(2'b00, 32'd3, 32'hFFFF_FFF0, 1'b0, 1'b0, "R4");
      // R4/R5 overflow with both mask values
      apply(2'b00, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R4");
      apply(2'b00, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, "R5");
      apply(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R4");
      // R2 subtract
      apply(2'b01, 32'd10, 32'd3, 1'b0, 1'b1, "R2");
      apply(2'b01, 32'd0, 32'h8000_0000, 1'b0, 1'b1, "R2");
      apply(2'b01, 32'h8000_0000, 32'd1, 1'b0, 1'b0, "R2");
      apply(2'b01, 32'd42, 32'd42, 1'b0, 1'b1, "R4");
      // R3 halfword with garbage in upper bits
      apply(2'b00, 32'd100, 32'hABCD_8000, 1'b1, 1'b1, "R3");
      apply(2'b01, 32'h8000_7FFF, 32'h1234_FFFF, 1'b1, 1'b1, "R3");
      apply(2'b00, 32'h7FFF_FFFF, 32'hFFFF_0001, 1'b1, 1'b1, "R3");
      // R6/R7 compare at extremes
      apply(2'b10, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1, "R6");
      apply(2'b11, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, "R6");
      apply(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R6");
      apply(2'b10, 32'hFFFF_8000, 32'h0000_8000, 1'b1, 1'b1, "R7");
      idle_cycle();

      for (int i = 0; i < 600; i++) begin
         logic [1:0] o;
         o = 2'($urandom);
         apply(o, pick(), pick(), ($urandom % 4) == 0, 1'($urandom), o[1] ? "R6" : "R4");
         if (($urandom % 8) == 0) idle_cycle();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule